// File: doc/BRIEF.md
# Shutter Timing Sequence Generator

This block produces a shutter level and a veto level for downstream detector devices. A shutter cycle begins at a start event. The start event is either a pulse on one selected trigger input or a tick from an internal periodic generator. From that start, the block counts strobe pulses. The strobe is a single-cycle enable in the system clock domain. Three programmable thresholds set when the shutter opens, when the veto is released, and when the shutter closes. The veto is raised again at the same moment the shutter closes.

The trigger inputs reach this block already conditioned. The block only taps them, so the same lines keep feeding the ordinary trigger decision logic elsewhere. The block also keeps a run-active flag. Writing a one to the run register sets the flag and sends a single-cycle sync pulse, which marks the start of a run.

Configuration uses a plain word-wide register port. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the address. There is no data stream here, so every pin is a plain control or status level.

Top module: `shutter_seq_gen`

## Requirements
- R1: After reset, `shutter_o` is 0, `veto_o` is 1, `run_active_o` is 0 and `sync_o` is 0. Every register reads back 0.
- R2: Register offsets are: 0 control (bit 0 enables), 1 source select, 2 generator period, 3 shutter-on count, 4 veto-release count, 5 shutter-off count, 6 run. A write stores the value and a read of the same offset returns it. Count fields are CNT_W bits wide and zero-extended on read.
- R3: While the enable bit is 0, no cycle starts, `shutter_o` stays 0 and `veto_o` stays 1. Clearing the enable bit ends a cycle that is in progress one clock after the write edge.
- R4: A select value below NUM_TRIG picks `trig_i[select]` as the start source, and pulses on the other trigger inputs are ignored. Any value of NUM_TRIG or above picks the internal generator.
- R5: With the internal generator selected and a period of P greater than 0, the generator makes one start event every P strobes. With P equal to 0, it makes no start events.
- R6: Let n be the number of strobes counted since the clock edge that accepted the start event. `shutter_o` is 1 exactly while on-count ≤ n < off-count.
- R7: `veto_o` is 0 exactly while veto-release-count ≤ n < off-count, and 1 otherwise.
- R8: When n reaches the off-count, the shutter falls and the veto rises in the same cycle. The cycle is over one clock later, and a new start can then be accepted.
- R9: A start event that arrives while a cycle is in progress is ignored and does not move the timeline.
- R10: n advances only on clock edges where `strobe_i` is 1.
- R11: A write to the run register with bit 0 set makes `run_active_o` 1 and drives `sync_o` high for the one following clock cycle. A write with bit 0 clear makes `run_active_o` 0 and does not pulse `sync_o`.
- R12: The thresholds are not checked for order. If the thresholds are out of order, each output follows its own window rule, and an empty window leaves that output at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Single-cycle count enable |
| trig_i | input | NUM_TRIG | Conditioned trigger pulses, one per input |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rd_data_o | output | DATA_W | Combinational read data for reg_addr_i |
| shutter_o | output | 1 | Shutter level to devices |
| veto_o | output | 1 | Veto level to devices |
| run_active_o | output | 1 | Run-active flag |
| sync_o | output | 1 | Start-of-run sync pulse |

## Verification
The hardest situation to reach from the ports is a start event that lands while a cycle is still open. It is ignored by design, so it leaves no direct trace on the outputs. The bench injects a second pulse on the selected trigger part-way through a cycle and keeps checking both outputs against a timeline counted from the first pulse only. The bench drives the strobe on only some cycles, so that cycles and strobe counts differ. The generator's fixed phase is checked by measuring the spacing between shutter rising edges. A very long cycle is cut short by clearing the enable bit, which shows the abort path.

// File: rtl/shutter_seq_pkg.sv
package shutter_seq_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_SEL    = 3'd1,
    ADR_PERIOD = 3'd2,
    ADR_T_ON   = 3'd3,
    ADR_T_VREL = 3'd4,
    ADR_T_OFF  = 3'd5,
    ADR_RUN    = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/shutter_seq_regs.sv
module shutter_seq_regs
  import shutter_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  en_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic [CNT_W-1:0]      period_o,
  output logic [CNT_W-1:0]      t_on_o,
  output logic [CNT_W-1:0]      t_vrel_o,
  output logic [CNT_W-1:0]      t_off_o,
  output logic                  run_active_o,
  output logic                  sync_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_o         <= 1'b0;
      sel_o        <= '0;
      period_o     <= '0;
      t_on_o       <= '0;
      t_vrel_o     <= '0;
      t_off_o      <= '0;
      run_active_o <= 1'b0;
      sync_o       <= 1'b0;
    end else begin
      sync_o <= 1'b0;
      if (wr_en_i) begin
        case (reg_addr_e'(addr_i))
          ADR_CTRL:   en_o     <= wdata_i[0];
          ADR_SEL:    sel_o    <= wdata_i[SEL_W-1:0];
          ADR_PERIOD: period_o <= wdata_i[CNT_W-1:0];
          ADR_T_ON:   t_on_o   <= wdata_i[CNT_W-1:0];
          ADR_T_VREL: t_vrel_o <= wdata_i[CNT_W-1:0];
          ADR_T_OFF:  t_off_o  <= wdata_i[CNT_W-1:0];
          ADR_RUN: begin
            run_active_o <= wdata_i[0];
            sync_o       <= wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      ADR_CTRL:   rdata_o = DATA_W'(en_o);
      ADR_SEL:    rdata_o = DATA_W'(sel_o);
      ADR_PERIOD: rdata_o = DATA_W'(period_o);
      ADR_T_ON:   rdata_o = DATA_W'(t_on_o);
      ADR_T_VREL: rdata_o = DATA_W'(t_vrel_o);
      ADR_T_OFF:  rdata_o = DATA_W'(t_off_o);
      ADR_RUN:    rdata_o = DATA_W'(run_active_o);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/shutter_start_sel.sv
module shutter_start_sel #(
  parameter int unsigned NUM_TRIG = 6,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                strobe_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [CNT_W-1:0]    period_i,
  output logic                start_o
);
  logic             use_int;
  logic             gen_run;
  logic             tick;
  logic             trig_pick;
  logic [CNT_W-1:0] gen_cnt;
  logic [NUM_TRIG-1:0] hit;

  assign use_int = (sel_i >= SEL_W'(NUM_TRIG));
  assign gen_run = en_i && use_int && (period_i != '0);
  assign tick    = gen_run && strobe_i && (gen_cnt >= period_i - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !gen_run) begin
      gen_cnt <= '0;
    end else if (strobe_i) begin
      if (tick) gen_cnt <= '0;
      else      gen_cnt <= gen_cnt + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_pick
    assign hit[i] = trig_i[i] && (sel_i == SEL_W'(i));
  end
  assign trig_pick = |hit;

  assign start_o = en_i && (use_int ? tick : trig_pick);
endmodule

// File: rtl/shutter_timer.sv
module shutter_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             strobe_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] t_on_i,
  input  logic [CNT_W-1:0] t_vrel_i,
  input  logic [CNT_W-1:0] t_off_i,
  output logic             shutter_o,
  output logic             veto_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic in_win;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (busy_o) begin
      if (cnt_o >= t_off_i) begin
        busy_o <= 1'b0;
        cnt_o  <= '0;
      end else if (strobe_i) begin
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_o  <= '0;
    end
  end

  assign in_win    = busy_o && (cnt_o < t_off_i);
  assign shutter_o = in_win && (cnt_o >= t_on_i);
  assign veto_o    = !(in_win && (cnt_o >= t_vrel_i));
endmodule

// File: rtl/shutter_seq_gen.sv
module shutter_seq_gen
  import shutter_seq_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                reg_wr_en_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rd_data_o,
  output logic                shutter_o,
  output logic                veto_o,
  output logic                run_active_o,
  output logic                sync_o
);
  localparam int unsigned SEL_W = $clog2(NUM_TRIG + 1);

  logic             ctrl_en;
  logic [SEL_W-1:0] src_sel;
  logic [CNT_W-1:0] gen_period;
  logic [CNT_W-1:0] t_on;
  logic [CNT_W-1:0] t_vrel;
  logic [CNT_W-1:0] t_off;
  logic             start_evt;
  logic             busy;
  logic [CNT_W-1:0] step_cnt;

  shutter_seq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr_en_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rd_data_o),
    .en_o(ctrl_en), .sel_o(src_sel), .period_o(gen_period),
    .t_on_o(t_on), .t_vrel_o(t_vrel), .t_off_o(t_off),
    .run_active_o(run_active_o), .sync_o(sync_o)
  );

  shutter_start_sel #(.NUM_TRIG(NUM_TRIG), .CNT_W(CNT_W), .SEL_W(SEL_W)) start_i (
    .clk_i, .rst_ni,
    .en_i(ctrl_en), .strobe_i(strobe_i), .trig_i(trig_i),
    .sel_i(src_sel), .period_i(gen_period), .start_o(start_evt)
  );

  shutter_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i, .rst_ni,
    .en_i(ctrl_en), .strobe_i(strobe_i), .start_i(start_evt),
    .t_on_i(t_on), .t_vrel_i(t_vrel), .t_off_i(t_off),
    .shutter_o(shutter_o), .veto_o(veto_o),
    .busy_o(busy), .cnt_o(step_cnt)
  );
endmodule

// File: rtl/shutter_seq_chk.sv
module shutter_seq_chk
  import shutter_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              reg_wr_en_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              shutter_o,
  input logic              veto_o,
  input logic              run_active_o,
  input logic              sync_o,
  input logic              ctrl_en,
  input logic              busy,
  input logic [CNT_W-1:0]  step_cnt,
  input logic [CNT_W-1:0]  t_off
);
  p_idle_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |=> (!shutter_o && veto_o));

  p_sync_needs_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> run_active_o);

  p_sync_from_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(reg_wr_en_i && (reg_addr_i == ADR_RUN) && reg_wdata_i[0]));

  p_hold_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en && busy && !strobe_i && (step_cnt < t_off)) |=> (step_cnt == $past(step_cnt)));

  p_close_together_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shutter_o) |-> veto_o);
endmodule

bind shutter_seq_gen shutter_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
  .reg_wr_en_i(reg_wr_en_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .shutter_o(shutter_o), .veto_o(veto_o),
  .run_active_o(run_active_o), .sync_o(sync_o),
  .ctrl_en(ctrl_en), .busy(busy), .step_cnt(step_cnt), .t_off(t_off)
);

// File: tb/shutter_seq_gen_tb_top.sv
module shutter_seq_gen_tb_top;
  localparam int NUM_TRIG = 6;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                strobe = 1'b0;
  logic [NUM_TRIG-1:0] trig = '0;
  logic                wr_en = 1'b0;
  logic [2:0]          addr = '0;
  logic [DATA_W-1:0]   wdata = '0;
  logic [DATA_W-1:0]   rdata;
  logic                shutter, veto, run_active, sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shutter_seq_gen #(.NUM_TRIG(NUM_TRIG), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .trig_i(trig),
    .reg_wr_en_i(wr_en), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rd_data_o(rdata), .shutter_o(shutter), .veto_o(veto),
    .run_active_o(run_active), .sync_o(sync)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic cfg(input int sel, input int t1, input int t2, input int t3);
    wr(3'd1, sel); wr(3'd3, t1); wr(3'd4, t2); wr(3'd5, t3); wr(3'd0, 1);
  endtask

  // Starts via trig_i[2]; strobe on every 'every'-th cycle; optional extra pulse mid-cycle.
  task automatic seq(input string req, input int t1, input int t2, input int t3,
                     input int every, input bit extra);
    int n = 0;
    trig[2] = 1'b1;
    @(negedge clk);
    trig[2] = 1'b0;
    for (int k = 0; k < 200; k++) begin
      chk({req, " shutter"}, shutter, (n >= t1 && n < t3));
      chk({req, " veto"},    veto,    !(n >= t2 && n < t3));
      if (n >= t3) break;
      strobe  = ((k % every) == 0);
      trig[2] = extra && (k == 2);
      if (strobe) n++;
      @(negedge clk);
      strobe  = 1'b0;
      trig[2] = 1'b0;
    end
    @(negedge clk);
    chk({req, " end shutter"}, shutter, 0);
    chk({req, " end veto"},    veto,    1);
  endtask

  task automatic t_reset;
    chk("R1 shutter", shutter, 0);
    chk("R1 veto", veto, 1);
    chk("R1 run", run_active, 0);
    chk("R1 sync", sync, 0);
    for (int a = 0; a < 7; a++) rd_chk("R1 readback", a[2:0], 0);
  endtask

  task automatic t_regs;
    wr(3'd3, 32'h0001_1234); rd_chk("R2 on-count", 3'd3, 32'h1234);
    wr(3'd2, 32'd77);        rd_chk("R2 period", 3'd2, 77);
    wr(3'd1, 32'd5);         rd_chk("R2 select", 3'd1, 5);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_run;
    wr(3'd6, 1);
    chk("R11 sync high", sync, 1);
    chk("R11 run set", run_active, 1);
    @(negedge clk);
    chk("R11 sync one cycle", sync, 0);
    wr(3'd6, 0);
    chk("R11 run clear", run_active, 0);
    chk("R11 no sync on clear", sync, 0);
  endtask

  task automatic t_wrong_input;
    cfg(2, 0, 0, 5);
    trig[0] = 1'b1; trig[5] = 1'b1;
    @(negedge clk);
    trig = '0;
    for (int k = 0; k < 4; k++) begin
      chk("R4 unselected shutter", shutter, 0);
      chk("R4 unselected veto", veto, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_internal;
    int last = -1, cyc = 0, gaps = 0;
    bit prev = 1'b0;
    cfg(NUM_TRIG, 0, 0, 1);
    wr(3'd2, 4);
    strobe = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); cyc++;
      if (shutter && !prev) begin
        if (last >= 0) begin chk("R5 period spacing", cyc - last, 4); gaps++; end
        last = cyc;
      end
      prev = shutter;
    end
    chk("R5 ticks seen", (gaps >= 3), 1);
    wr(3'd2, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R5 period zero idle", shutter, 0);
    end
    strobe = 1'b0;
  endtask

  task automatic t_disable;
    cfg(2, 0, 0, 100);
    trig[2] = 1'b1; @(negedge clk); trig[2] = 1'b0;
    chk("R3 cycle open", shutter, 1);
    wr(3'd0, 0);
    @(negedge clk);
    chk("R3 abort shutter", shutter, 0);
    chk("R3 abort veto", veto, 1);
    trig[2] = 1'b1; @(negedge clk); trig[2] = 1'b0;
    @(negedge clk);
    chk("R3 disabled no start", shutter, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_run();
    cfg(2, 2, 3, 5);
    seq("R6 R7 R8 dense", 2, 3, 5, 1, 0);
    seq("R10 sparse strobe", 2, 3, 5, 3, 0);
    seq("R9 restart ignored", 2, 3, 5, 2, 1);
    seq("R8 back to back", 2, 3, 5, 1, 0);
    cfg(2, 4, 1, 3);
    seq("R12 misordered", 4, 1, 3, 1, 0);
    t_wrong_input();
    t_internal();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule